// File: doc/BRIEF.md
# CORDIC Digital Down-Converter Front End

This block sits between a bank of real-valued sample converters and a later decimation filter. Four 12-bit converter streams, all sampled on the same strobe, pass through a per-channel routing stage. For each complex channel it picks one converter for the in-phase input and one for the quadrature input. Either input may be switched off, and a channel may be set to real mode, where its quadrature input is held at zero. Each chosen sample is widened to a signed 16-bit value. The rotation engine that follows treats the pair as a complex number.

Each channel has its own phase accumulator, which steps by a programmable increment on every valid sample. A pipelined CORDIC rotator turns the channel's complex sample by the negative of that phase, which shifts the wanted band down to baseband. First a coarse quarter-turn step brings the angle into ±π/2. Sixteen shift-and-add stages then close the remaining angle. The fixed CORDIC gain is left in the result, and the result is clamped to 16 bits. A single valid strobe goes with the I/Q pairs of all channels.

The routing and phase-increment settings are plain input ports, which are expected to be driven from configuration registers elsewhere. They are sampled together with the data, so a change takes effect on the next sample that is accepted.

Top module: `ddc_front_end`

## Requirements
- R1: Each 12-bit two's-complement converter sample becomes a signed 16-bit value. The 12 bits are placed in bits 15..4 and bits 3..0 are zero, so the value is the sample times 16.
- R2: For channel c, the 2-bit field `sel_i_i[2c+1:2c]` picks the converter index (0 to 3) that feeds the in-phase input, and `sel_q_i[2c+1:2c]` picks the one that feeds the quadrature input.
- R3: When `use_i_i[c]` is 0, the in-phase input of channel c is zero whatever converter is selected. When `use_q_i[c]` is 0, the same holds for the quadrature input.
- R4: When `real_mode_i[c]` is 1, the quadrature input of channel c is zero whatever the values of `sel_q_i` and `use_q_i`. The in-phase input is unaffected.
- R5: Each channel keeps a 32-bit phase accumulator that is cleared by reset. It adds `phase_inc_i[32c+31:32c]` once for each accepted valid sample and holds its value on other cycles. The n-th valid sample after reset (counting from n = 0) uses the accumulator value reached after the n earlier additions.
- R6: Let φ = 2π·A/65536, where A is the top 16 bits of the accumulator for the sample. Channel outputs are I = K·(x·cosφ + y·sinφ) and Q = K·(y·cosφ − x·sinφ). Here x and y are the 16-bit inputs and K ≈ 1.6468. The result holds within 16 LSB for every angle, the exact quarter and half turns included.
- R7: An output whose ideal value lies outside the 16-bit range is clamped to 32767 or −32768. It never wraps.
- R8: `valid_o` equals `adc_valid_i` delayed by exactly 18 clock cycles (stage count plus 2). The data on `i_o`/`q_o` that goes with it is present in the same cycle.
- R9: While reset is asserted, and until the first accepted sample comes out of the pipeline, `valid_o` is 0. During reset the data outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| adc_i | input | 48 | Four 12-bit converter samples; converter k in bits 12k+11..12k |
| adc_valid_i | input | 1 | Samples on adc_i are valid this cycle |
| sel_i_i | input | 4 | Per-channel converter index for the in-phase input, 2 bits per channel |
| sel_q_i | input | 4 | Per-channel converter index for the quadrature input, 2 bits per channel |
| use_i_i | input | 2 | Per-channel in-phase input enable |
| use_q_i | input | 2 | Per-channel quadrature input enable |
| real_mode_i | input | 2 | Per-channel real mode; forces the quadrature input to zero |
| phase_inc_i | input | 64 | Per-channel 32-bit phase increment |
| i_o | output | 32 | Per-channel 16-bit in-phase result |
| q_o | output | 32 | Per-channel 16-bit quadrature result |
| valid_o | output | 1 | Results on i_o/q_o are valid |

## Verification
The bench feeds an increment of a quarter turn on one channel and a half turn on the other. This drives the angle onto ±π/2 and onto −π exactly. A pre-rotation with the wrong comparison bound, or with the two directions swapped, would then give outputs in the wrong quadrant or with the wrong sign. Valid gaps are placed in the sample stream: a phase accumulator that advanced on idle cycles would drift from the reference, and so would a valid pipeline one stage too long or too short. Full-scale inputs at zero phase and at 45° push the result beyond 16 bits, so a missing clamp shows up as a wrapped value of the opposite sign. Routing cases pair every channel with different converters and turn each input off, and real mode is run with a live quadrature source, so a crossed selector, or an enable or real-mode bit that is ignored, leaves an error far larger than the tolerance.

// File: rtl/ddc_pkg.sv
package ddc_pkg;

  // rotation angle width; the arctangent table below is scaled for it
  localparam int ANG_W = 16;

  // atan(2^-k) with a quarter turn = 2^16 units
  function automatic int cordic_atan(input int k);
    case (k)
      0:  return 32768;
      1:  return 19344;
      2:  return 10221;
      3:  return 5188;
      4:  return 2604;
      5:  return 1303;
      6:  return 652;
      7:  return 326;
      8:  return 163;
      9:  return 81;
      10: return 41;
      11: return 20;
      12: return 10;
      13: return 5;
      14: return 3;
      15: return 1;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/ddc_input_route.sv
module ddc_input_route #(
  parameter int NUM_ADC = 4,
  parameter int ADC_W   = 12,
  parameter int SMP_W   = 16,
  localparam int SEL_W  = $clog2(NUM_ADC)
) (
  input  logic [NUM_ADC*ADC_W-1:0] adc_i,
  input  logic [SEL_W-1:0]         sel_i_i,
  input  logic [SEL_W-1:0]         sel_q_i,
  input  logic                     use_i_i,
  input  logic                     use_q_i,
  input  logic                     real_mode_i,
  output logic signed [SMP_W-1:0]  i_o,
  output logic signed [SMP_W-1:0]  q_o
);

  localparam int PAD_W = SMP_W - ADC_W;

  logic signed [SMP_W-1:0] conv [NUM_ADC];

  // left-justify each converter sample into the wider word
  for (genvar g = 0; g < NUM_ADC; g++) begin : g_conv
    assign conv[g] = {adc_i[g*ADC_W +: ADC_W], {PAD_W{1'b0}}};
  end

  always_comb begin
    i_o = use_i_i ? conv[sel_i_i] : '0;
    q_o = (use_q_i && !real_mode_i) ? conv[sel_q_i] : '0;
  end

endmodule

// File: rtl/ddc_nco.sv
module ddc_nco #(
  parameter int ACC_W = 32,
  parameter int ANG_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  input  logic [ACC_W-1:0] inc_i,
  output logic [ANG_W-1:0] ang_o,
  output logic [ACC_W-1:0] acc_o
);

  logic [ACC_W-1:0] acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    acc_q <= '0;
    else if (adv_i) acc_q <= acc_q + inc_i;
  end

  assign ang_o = acc_q[ACC_W-1 -: ANG_W];
  assign acc_o = acc_q;

endmodule

// File: rtl/ddc_cordic.sv
module ddc_cordic
  import ddc_pkg::*;
#(
  parameter int SMP_W  = 16,
  parameter int STAGES = 16,
  parameter int GUARD  = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic signed [SMP_W-1:0] x_i,
  input  logic signed [SMP_W-1:0] y_i,
  input  logic [ANG_W-1:0]        ang_i,
  output logic signed [SMP_W-1:0] i_o,
  output logic signed [SMP_W-1:0] q_o
);

  localparam int IW  = SMP_W + 2 + GUARD;  // gain growth plus guard bits
  localparam int ZW  = ANG_W + 3;
  localparam int OW  = IW - GUARD;
  localparam int QTR = 1 << (ANG_W - 2);
  localparam logic signed [ANG_W-1:0] QTR_A = ANG_W'(QTR);
  localparam logic signed [OW-1:0]    HI    = OW'((1 << (SMP_W - 1)) - 1);
  localparam logic signed [OW-1:0]    LO    = -HI - OW'(1);

  logic signed [IW-1:0]    xe, ye, xp, yp;
  logic signed [ANG_W-1:0] a, ap;

  // quarter-turn pre-rotation keeps the residual within +-pi/2
  always_comb begin
    xe = IW'(x_i) <<< GUARD;
    ye = IW'(y_i) <<< GUARD;
    a  = signed'(ang_i);
    if (int'(a) > QTR) begin
      xp = -ye;
      yp = xe;
      ap = a - QTR_A;
    end else if (int'(a) < -QTR) begin
      xp = ye;
      yp = -xe;
      ap = a + QTR_A;
    end else begin
      xp = xe;
      yp = ye;
      ap = a;
    end
  end

  logic signed [IW-1:0] xs [STAGES+1];
  logic signed [IW-1:0] ys [STAGES+1];
  logic signed [ZW-1:0] zs [STAGES+1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k <= STAGES; k++) begin
        xs[k] <= '0;
        ys[k] <= '0;
        zs[k] <= '0;
      end
    end else begin
      xs[0] <= xp;
      ys[0] <= yp;
      zs[0] <= {ap[ANG_W-1], ap, 2'b00};
      for (int k = 0; k < STAGES; k++) begin
        if (zs[k][ZW-1]) begin
          xs[k+1] <= xs[k] + (ys[k] >>> k);
          ys[k+1] <= ys[k] - (xs[k] >>> k);
          zs[k+1] <= zs[k] + ZW'(cordic_atan(k));
        end else begin
          xs[k+1] <= xs[k] - (ys[k] >>> k);
          ys[k+1] <= ys[k] + (xs[k] >>> k);
          zs[k+1] <= zs[k] - ZW'(cordic_atan(k));
        end
      end
    end
  end

  function automatic logic signed [SMP_W-1:0] clamp(input logic signed [OW-1:0] v);
    if (v > HI)      return {1'b0, {(SMP_W-1){1'b1}}};
    else if (v < LO) return {1'b1, {(SMP_W-1){1'b0}}};
    else             return v[SMP_W-1:0];
  endfunction

  logic signed [IW-1:0] xf, yf;
  always_comb begin
    xf  = xs[STAGES] >>> GUARD;
    yf  = ys[STAGES] >>> GUARD;
    i_o = clamp(xf[OW-1:0]);
    q_o = clamp(yf[OW-1:0]);
  end

endmodule

// File: rtl/ddc_front_end.sv
module ddc_front_end
  import ddc_pkg::*;
#(
  parameter int NUM_ADC = 4,
  parameter int NUM_CH  = 2,
  parameter int ADC_W   = 12,
  parameter int SMP_W   = 16,
  parameter int ACC_W   = 32,
  parameter int STAGES  = 16,
  parameter int GUARD   = 2,
  localparam int SEL_W  = $clog2(NUM_ADC),
  localparam int LAT    = STAGES + 2
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NUM_ADC*ADC_W-1:0]  adc_i,
  input  logic                      adc_valid_i,
  input  logic [NUM_CH*SEL_W-1:0]   sel_i_i,
  input  logic [NUM_CH*SEL_W-1:0]   sel_q_i,
  input  logic [NUM_CH-1:0]         use_i_i,
  input  logic [NUM_CH-1:0]         use_q_i,
  input  logic [NUM_CH-1:0]         real_mode_i,
  input  logic [NUM_CH*ACC_W-1:0]   phase_inc_i,
  output logic [NUM_CH*SMP_W-1:0]   i_o,
  output logic [NUM_CH*SMP_W-1:0]   q_o,
  output logic                      valid_o
);

  logic [NUM_CH*SMP_W-1:0] s1_i_flat, s1_q_flat;
  logic [NUM_CH*ACC_W-1:0] acc_flat;
  logic [LAT-1:0]          vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vld_q <= '0;
    else         vld_q <= {vld_q[LAT-2:0], adc_valid_i};
  end
  assign valid_o = vld_q[LAT-1];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic signed [SMP_W-1:0] rt_i, rt_q, s1_x, s1_y;
    logic [ANG_W-1:0]        ang, s1_a;
    logic signed [SMP_W-1:0] ro_i, ro_q;

    ddc_input_route #(
      .NUM_ADC(NUM_ADC), .ADC_W(ADC_W), .SMP_W(SMP_W)
    ) u_route (
      .adc_i      (adc_i),
      .sel_i_i    (sel_i_i[c*SEL_W +: SEL_W]),
      .sel_q_i    (sel_q_i[c*SEL_W +: SEL_W]),
      .use_i_i    (use_i_i[c]),
      .use_q_i    (use_q_i[c]),
      .real_mode_i(real_mode_i[c]),
      .i_o        (rt_i),
      .q_o        (rt_q)
    );

    ddc_nco #(.ACC_W(ACC_W), .ANG_W(ANG_W)) u_nco (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .adv_i (adc_valid_i),
      .inc_i (phase_inc_i[c*ACC_W +: ACC_W]),
      .ang_o (ang),
      .acc_o (acc_flat[c*ACC_W +: ACC_W])
    );

    // capture stage; the angle is negated so the rotation moves down in frequency
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_x <= '0;
        s1_y <= '0;
        s1_a <= '0;
      end else begin
        s1_x <= rt_i;
        s1_y <= rt_q;
        s1_a <= -ang;
      end
    end
    assign s1_i_flat[c*SMP_W +: SMP_W] = s1_x;
    assign s1_q_flat[c*SMP_W +: SMP_W] = s1_y;

    ddc_cordic #(.SMP_W(SMP_W), .STAGES(STAGES), .GUARD(GUARD)) u_cordic (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .x_i   (s1_x),
      .y_i   (s1_y),
      .ang_i (s1_a),
      .i_o   (ro_i),
      .q_o   (ro_q)
    );
    assign i_o[c*SMP_W +: SMP_W] = ro_i;
    assign q_o[c*SMP_W +: SMP_W] = ro_q;
  end

endmodule

// File: rtl/ddc_front_end_chk.sv
module ddc_front_end_chk #(
  parameter int NUM_CH = 2,
  parameter int SMP_W  = 16,
  parameter int ACC_W  = 32,
  parameter int LAT    = 18
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    adc_valid_i,
  input logic                    valid_o,
  input logic [NUM_CH-1:0]       use_i_i,
  input logic [NUM_CH-1:0]       real_mode_i,
  input logic [NUM_CH*ACC_W-1:0] phase_inc_i,
  input logic [NUM_CH*SMP_W-1:0] s1_i_i,
  input logic [NUM_CH*SMP_W-1:0] s1_q_i,
  input logic [NUM_CH*ACC_W-1:0] acc_i
);

  localparam int CW = $clog2(LAT + 1);

  logic [LAT-1:0] hist;
  logic [CW-1:0]  since_rst;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist      <= '0;
      since_rst <= '0;
    end else begin
      hist <= {hist[LAT-2:0], adc_valid_i};
      if (since_rst != CW'(LAT)) since_rst <= since_rst + 1'b1;
    end
  end

  p_valid_delay_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == hist[LAT-1]);

  p_quiet_after_reset_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst < CW'(LAT)) |-> !valid_o);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    p_real_q_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(real_mode_i[c]) |-> (s1_q_i[c*SMP_W +: SMP_W] == '0));

    p_unused_i_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(!use_i_i[c]) |-> (s1_i_i[c*SMP_W +: SMP_W] == '0));

    p_phase_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(rst_ni) && $past(adc_valid_i)) |->
        acc_i[c*ACC_W +: ACC_W] == $past(acc_i[c*ACC_W +: ACC_W]) + $past(phase_inc_i[c*ACC_W +: ACC_W]));

    p_phase_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(rst_ni) && !$past(adc_valid_i)) |-> $stable(acc_i[c*ACC_W +: ACC_W]));
  end

endmodule

bind ddc_front_end ddc_front_end_chk #(
  .NUM_CH(NUM_CH), .SMP_W(SMP_W), .ACC_W(ACC_W), .LAT(LAT)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .adc_valid_i(adc_valid_i),
  .valid_o    (valid_o),
  .use_i_i    (use_i_i),
  .real_mode_i(real_mode_i),
  .phase_inc_i(phase_inc_i),
  .s1_i_i     (s1_i_flat),
  .s1_q_i     (s1_q_flat),
  .acc_i      (acc_flat)
);

// File: tb/sim_ddc_front_end.sv
module sim_ddc_front_end;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int NCH = 2;
  localparam int NADC = 4;
  localparam int LAT = 18;
  localparam real TOL = 16.0;
  localparam real TWO_PI = 6.283185307179586;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_ni;
  logic [47:0]   adc_p;
  logic          vld;
  logic [3:0]    sel_i_p, sel_q_p;
  logic [1:0]    use_i_p, use_q_p, real_p;
  logic [63:0]   inc_p;
  logic [31:0]   i_o, q_o;
  logic          valid_o;

  ddc_front_end u0 (
    .clk_i(clk), .rst_ni(rst_ni), .adc_i(adc_p), .adc_valid_i(vld),
    .sel_i_i(sel_i_p), .sel_q_i(sel_q_p), .use_i_i(use_i_p), .use_q_i(use_q_p),
    .real_mode_i(real_p), .phase_inc_i(inc_p),
    .i_o(i_o), .q_o(q_o), .valid_o(valid_o)
  );

  int checks = 0;
  int fails = 0;
  bit done = 0;
  string req = "R6";
  real kg;

  int adc_v[NADC];
  int sel_iv[NCH], sel_qv[NCH];
  bit use_iv[NCH], use_qv[NCH], real_v[NCH];
  longint incv[NCH];
  longint acc_m[NCH];

  bit    vq[$];
  real   eiq[$], eqq[$];
  string rq[$];

  task automatic chk_num(string r, int act, real exp);
    real d;
    checks++;
    d = real'(act) - exp;
    if (d > TOL || d < -TOL) begin
      fails++;
      $display("FAIL %s: got %0d expected %0.1f", r, act, exp);
    end
  endtask

  task automatic chk_bit(string r, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0b expected %0b", r, act, exp);
    end
  endtask

  function automatic real clip(real v);
    if (v > 32767.0) return 32767.0;
    if (v < -32768.0) return -32768.0;
    return v;
  endfunction

  // one cycle: check what the design shows now, then drive the next inputs
  task automatic step(bit v);
    @(negedge clk);
    if (vq.size() == LAT) begin
      bit ev;
      string r;
      ev = vq.pop_front();
      r = rq.pop_front();
      chk_bit("R8", valid_o, ev);
      for (int c = 0; c < NCH; c++) begin
        real ei, eq;
        ei = eiq.pop_front();
        eq = eqq.pop_front();
        if (ev) begin
          chk_num(r, int'($signed(i_o[c*16 +: 16])), ei);
          chk_num(r, int'($signed(q_o[c*16 +: 16])), eq);
        end
      end
    end
    for (int c = 0; c < NCH; c++) begin
      real x, y, phi, ei, eq;
      x = use_iv[c] ? real'(adc_v[sel_iv[c]] * 16) : 0.0;
      y = (use_qv[c] && !real_v[c]) ? real'(adc_v[sel_qv[c]] * 16) : 0.0;
      phi = real'((acc_m[c] >> 16) & 64'hFFFF) * TWO_PI / 65536.0;
      ei = clip(kg * (x * $cos(phi) + y * $sin(phi)));
      eq = clip(kg * (y * $cos(phi) - x * $sin(phi)));
      eiq.push_back(ei);
      eqq.push_back(eq);
      if (v) acc_m[c] = (acc_m[c] + incv[c]) & 64'hFFFF_FFFF;
    end
    vq.push_back(v);
    rq.push_back(req);
    vld = v;
    for (int k = 0; k < NADC; k++) adc_p[k*12 +: 12] = adc_v[k][11:0];
    for (int c = 0; c < NCH; c++) begin
      sel_i_p[c*2 +: 2] = sel_iv[c][1:0];
      sel_q_p[c*2 +: 2] = sel_qv[c][1:0];
      use_i_p[c] = use_iv[c];
      use_q_p[c] = use_qv[c];
      real_p[c]  = real_v[c];
      inc_p[c*32 +: 32] = incv[c][31:0];
    end
  endtask

  task automatic rand_adc();
    for (int k = 0; k < NADC; k++) adc_v[k] = int'($urandom_range(4095)) - 2048;
  endtask

  task automatic run(int n, bit gaps);
    for (int s = 0; s < n; s++) begin
      rand_adc();
      step(gaps ? ($urandom_range(2) != 0) : 1'b1);
    end
  endtask

  task automatic drain();
    for (int s = 0; s < LAT + 2; s++) step(1'b0);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    kg = 1.0;
    for (int i = 0; i < 16; i++) kg = kg * $sqrt(1.0 + 2.0 ** (-2.0 * i));
    for (int k = 0; k < NADC; k++) adc_v[k] = 0;
    for (int c = 0; c < NCH; c++) begin
      sel_iv[c] = c; sel_qv[c] = c + 2;
      use_iv[c] = 1; use_qv[c] = 1; real_v[c] = 0;
      incv[c] = 0; acc_m[c] = 0;
    end
    rst_ni = 1'b0; vld = 1'b0; adc_p = '0;
    sel_i_p = '0; sel_q_p = '0; use_i_p = '0; use_q_p = '0; real_p = '0; inc_p = '0;
    repeat (4) @(negedge clk);
    // R9: quiet outputs while held in reset
    chk_bit("R9", valid_o, 1'b0);
    chk_num("R9", int'($signed(i_o[15:0])), 0.0);
    chk_num("R9", int'($signed(q_o[31:16])), 0.0);
    rst_ni = 1'b1;
    for (int s = 0; s < LAT; s++) begin
      vq.push_back(1'b0); rq.push_back("R9");
      for (int c = 0; c < NCH; c++) begin eiq.push_back(0.0); eqq.push_back(0.0); end
    end

    // R1: zero phase, known extremes on a single in-phase source
    req = "R1";
    sel_iv[0] = 0; use_qv[0] = 0; sel_iv[1] = 1; sel_qv[1] = 2;
    foreach (adc_v[k]) adc_v[k] = 0;
    adc_v[0] = -2048; adc_v[1] = 5;    adc_v[2] = -7; step(1);
    adc_v[0] = 2047;  adc_v[1] = -1;   adc_v[2] = 1;  step(1);
    adc_v[0] = 1;     adc_v[1] = 1000; adc_v[2] = 0;  step(1);
    adc_v[0] = -1;    adc_v[1] = -999; adc_v[2] = 77; step(1);
    drain();

    // R2: crossed routing with nonzero increments
    req = "R2";
    sel_iv[0] = 2; sel_qv[0] = 3; use_qv[0] = 1;
    sel_iv[1] = 3; sel_qv[1] = 0;
    incv[0] = 64'h0123_4567; incv[1] = 64'hF000_0000;
    run(40, 1'b0);
    drain();

    // R3: disabled inputs contribute nothing
    req = "R3";
    use_iv[0] = 0; use_qv[0] = 1; use_iv[1] = 1; use_qv[1] = 0;
    run(20, 1'b0);
    drain();

    // R4: real mode kills quadrature despite live selection
    req = "R4";
    use_iv[0] = 1; use_qv[0] = 1; use_qv[1] = 1;
    real_v[0] = 1; real_v[1] = 1;
    run(20, 1'b0);
    real_v[0] = 0; real_v[1] = 0;
    drain();

    // R5: quarter and half turn steps with idle gaps
    req = "R5";
    incv[0] = 64'h4000_0000; incv[1] = 64'h8000_0000;
    run(40, 1'b1);
    incv[0] = 64'hC000_0000; incv[1] = 64'h2000_0000;
    run(30, 1'b1);
    drain();

    // R6: arbitrary increments, gaps
    req = "R6";
    for (int r = 0; r < 4; r++) begin
      incv[0] = longint'($urandom); incv[1] = longint'($urandom);
      run(30, 1'b1);
    end
    drain();

    // R7: full-scale inputs must clamp
    req = "R7";
    sel_iv[0] = 0; sel_qv[0] = 1; sel_iv[1] = 2; sel_qv[1] = 3;
    incv[0] = 0; incv[1] = 64'h2000_0000;
    for (int s = 0; s < 12; s++) begin
      int fs;
      fs = (s % 2 == 0) ? -2048 : 2047;
      foreach (adc_v[k]) adc_v[k] = fs;
      step(1);
    end
    adc_v[0] = 2047; adc_v[1] = -2048; adc_v[2] = -2048; adc_v[3] = 2047;
    step(1);
    drain();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule